// File: doc/BRIEF.md
# Trace Trigger and Marker Router

This block sits between the event sources of a trace collector and its record path. It receives single-cycle pulses for local and global triggers and for local and global markers. For each pulse it decides three things: whether a local event is passed on to the global fabric, whether the event becomes a record in the trace stream, and whether it starts or stops tracing. Two small mode fields make these decisions, one for triggers and one for markers. Each mode picks local-only, global-only or mixed routing.

The block also gathers the reasons for stopping a trace. These are a set of debug trigger inputs, each with its own enable, the falling edge of a run input, and a checkstop input. The checkstop stop is disabled by setting its control bit. From the control triggers and the stop sources the block keeps a single trace-run state and reports it, together with one-cycle start and stop pulses.

All outputs are registered and change one clock after the inputs that cause them. Insert requests are single-cycle pulses with no handshake, because the event sources cannot be held off. Each record type has its own lane, so events that arrive in the same cycle are never lost.

Top module: `trace_event_router`

## Requirements
- R1: While reset is held and in the first cycle after it, trace_on, start_pulse, stop_pulse, fwd_trig, fwd_mark and every lane of ins_pulse are 0.
- R2: With trig_mode 00, a local trigger is not forwarded. A local trigger raises ins_pulse[0] only while tracing. Both local and global triggers act as control triggers.
- R3: With trig_mode 01, a local trigger is not forwarded and raises ins_pulse[0] only while tracing. Only local triggers act as control triggers, and a global trigger does not change the trace state.
- R4: With trig_mode 10 or 11, a local trigger raises fwd_trig and never ins_pulse[0]. Only global triggers act as control triggers. In every trigger mode, a global trigger raises ins_pulse[1] while tracing.
- R5: With mark_mode 00, local and global markers raise ins_pulse[2] and ins_pulse[3] while tracing, and nothing is forwarded. With mark_mode 01, only local markers are inserted (ins_pulse[2]) and nothing is forwarded.
- R6: With mark_mode 10, a local marker raises fwd_mark and only global markers are inserted (ins_pulse[3]). With mark_mode 11, a local marker raises fwd_mark and no marker is inserted.
- R7: When not tracing, a control trigger starts tracing and gives a one-cycle start_pulse. When tracing, a control trigger stops tracing and gives a one-cycle stop_pulse. "While tracing" means the trace_on value before the event.
- R8: A stop source active in the same cycle as a control trigger wins. Tracing ends, or stays off, and no start_pulse appears.
- R9: A debug trigger input dbg_trig[i] stops tracing only when dbg_stop_en[i] is 1.
- R10: A falling edge of run_in (1 in one cycle, 0 in the next) stops tracing when run_stop_en is 1. A falling edge has no effect when run_stop_en is 0.
- R11: chkstop stops tracing when chk_stop_off is 0. chkstop has no effect when chk_stop_off is 1.
- R12: Every output reflects its inputs one clock later. In the cycle of the input pulse itself, no output has changed yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_mode | input | 2 | Trigger routing mode |
| mark_mode | input | 2 | Marker routing mode |
| loc_trig | input | 1 | Local trigger pulse |
| glb_trig | input | 1 | Global trigger pulse from the fabric |
| loc_mark | input | 1 | Local marker pulse |
| glb_mark | input | 1 | Global marker pulse from the fabric |
| dbg_trig | input | N_DBG | Debug trigger stop sources |
| dbg_stop_en | input | N_DBG | Per-debug-trigger stop enable |
| run_in | input | 1 | Run level; its falling edge is a stop source |
| run_stop_en | input | 1 | Enables the stop on a run falling edge |
| chkstop | input | 1 | Checkstop stop source |
| chk_stop_off | input | 1 | 1 disables the checkstop stop; 0 enables it |
| fwd_trig | output | 1 | Local trigger forwarded to the fabric |
| fwd_mark | output | 1 | Local marker forwarded to the fabric |
| ins_pulse | output | 4 | Insert lanes: 0 local trigger, 1 global trigger, 2 local marker, 3 global marker |
| trace_on | output | 1 | Trace-run state |
| start_pulse | output | 1 | One-cycle pulse when tracing starts |
| stop_pulse | output | 1 | One-cycle pulse when tracing stops |

## Verification
Several properties are checked by assertions on every cycle:
- start and stop pulses never occur together, and a rise of trace_on always comes with a start pulse;
- forwarding only follows a local event in a forwarding mode;
- no insert occurs while tracing is off;
- an enabled debug trigger or checkstop always leaves tracing off.

Other behaviour can only be shown by the bench's scenarios:
- the full decision table across every mode pair and event combination;
- start and stop toggling by the control trigger;
- the priority of a stop over a start, and the run falling-edge stop;
- the one-cycle latency.

// File: rtl/tev_pkg.sv
package tev_pkg;
  typedef enum logic [1:0] {
    MRK_BOTH   = 2'b00,
    MRK_LOCAL  = 2'b01,
    MRK_GLOBAL = 2'b10,
    MRK_NONE   = 2'b11
  } mark_mode_e;

  typedef enum logic [1:0] {
    TRG_MIXED  = 2'b00,
    TRG_LOCAL  = 2'b01,
    TRG_FWD_A  = 2'b10,
    TRG_FWD_B  = 2'b11
  } trig_mode_e;

  localparam int LANE_LT = 0;
  localparam int LANE_GT = 1;
  localparam int LANE_LM = 2;
  localparam int LANE_GM = 3;
  localparam int NUM_LANES = 4;
endpackage

// File: rtl/tev_route.sv
module tev_route
  import tev_pkg::*;
(
  input  logic [1:0]           trig_mode,
  input  logic [1:0]           mark_mode,
  input  logic                 loc_trig,
  input  logic                 glb_trig,
  input  logic                 loc_mark,
  input  logic                 glb_mark,
  input  logic                 tracing,
  output logic                 ctl_hit,
  output logic                 fwd_trig_d,
  output logic                 fwd_mark_d,
  output logic [NUM_LANES-1:0] ins_d
);
  trig_mode_e tm;
  mark_mode_e mm;
  logic lt_insert_ok;
  logic lm_insert_ok;
  logic gm_insert_ok;

  assign tm = trig_mode_e'(trig_mode);
  assign mm = mark_mode_e'(mark_mode);

  always_comb begin
    ctl_hit      = 1'b0;
    fwd_trig_d   = 1'b0;
    lt_insert_ok = 1'b0;
    unique case (tm)
      TRG_MIXED: begin
        ctl_hit      = loc_trig | glb_trig;
        lt_insert_ok = 1'b1;
      end
      TRG_LOCAL: begin
        ctl_hit      = loc_trig;
        lt_insert_ok = 1'b1;
      end
      TRG_FWD_A, TRG_FWD_B: begin
        ctl_hit    = glb_trig;
        fwd_trig_d = loc_trig;
      end
      default: ;
    endcase
  end

  always_comb begin
    fwd_mark_d   = 1'b0;
    lm_insert_ok = 1'b0;
    gm_insert_ok = 1'b0;
    unique case (mm)
      MRK_BOTH:   begin lm_insert_ok = 1'b1; gm_insert_ok = 1'b1; end
      MRK_LOCAL:  lm_insert_ok = 1'b1;
      MRK_GLOBAL: begin fwd_mark_d = loc_mark; gm_insert_ok = 1'b1; end
      MRK_NONE:   fwd_mark_d = loc_mark;
      default: ;
    endcase
  end

  always_comb begin
    ins_d          = '0;
    ins_d[LANE_LT] = tracing & loc_trig & lt_insert_ok;
    ins_d[LANE_GT] = tracing & glb_trig;
    ins_d[LANE_LM] = tracing & loc_mark & lm_insert_ok;
    ins_d[LANE_GM] = tracing & glb_mark & gm_insert_ok;
  end
endmodule

// File: rtl/tev_stop_collect.sv
module tev_stop_collect #(
  parameter int N_DBG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DBG-1:0] dbg_trig,
  input  logic [N_DBG-1:0] dbg_stop_en,
  input  logic             run_in,
  input  logic             run_stop_en,
  input  logic             chkstop,
  input  logic             chk_stop_off,
  output logic             stop_hit
);
  logic             run_q;
  logic             run_fall;
  logic [N_DBG-1:0] dbg_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_in;
  end

  assign run_fall = run_q & ~run_in;

  for (genvar i = 0; i < N_DBG; i++) begin : g_dbg
    assign dbg_hit[i] = dbg_trig[i] & dbg_stop_en[i];
  end

  assign stop_hit = (|dbg_hit) | (run_fall & run_stop_en) | (chkstop & ~chk_stop_off);
endmodule

// File: rtl/tev_run_fsm.sv
module tev_run_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_hit,
  input  logic stop_hit,
  output logic trace_on,
  output logic start_pulse,
  output logic stop_pulse
);
  logic trace_d;
  logic start_d;
  logic stop_d;

  always_comb begin
    start_d = 1'b0;
    stop_d  = 1'b0;
    trace_d = trace_on;
    if (trace_on) begin
      if (stop_hit || ctl_hit) begin
        trace_d = 1'b0;
        stop_d  = 1'b1;
      end
    end else if (ctl_hit && !stop_hit) begin
      trace_d = 1'b1;
      start_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trace_on    <= 1'b0;
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
    end else begin
      trace_on    <= trace_d;
      start_pulse <= start_d;
      stop_pulse  <= stop_d;
    end
  end

  // R7: start and stop never coincide
  a_r7_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && stop_pulse));
  // R7: a rise of the run state is always announced
  a_r7_rise_has_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trace_on) |-> start_pulse);
  // R8: a stop source leaves tracing off next cycle
  a_r8_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> !trace_on);
endmodule

// File: rtl/trace_event_router.sv
module trace_event_router
  import tev_pkg::*;
#(
  parameter int N_DBG = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           trig_mode,
  input  logic [1:0]           mark_mode,
  input  logic                 loc_trig,
  input  logic                 glb_trig,
  input  logic                 loc_mark,
  input  logic                 glb_mark,
  input  logic [N_DBG-1:0]     dbg_trig,
  input  logic [N_DBG-1:0]     dbg_stop_en,
  input  logic                 run_in,
  input  logic                 run_stop_en,
  input  logic                 chkstop,
  input  logic                 chk_stop_off,
  output logic                 fwd_trig,
  output logic                 fwd_mark,
  output logic [NUM_LANES-1:0] ins_pulse,
  output logic                 trace_on,
  output logic                 start_pulse,
  output logic                 stop_pulse
);
  logic                 ctl_hit;
  logic                 stop_hit;
  logic                 fwd_trig_d;
  logic                 fwd_mark_d;
  logic [NUM_LANES-1:0] ins_d;

  tev_route u_route (
    .trig_mode  (trig_mode),
    .mark_mode  (mark_mode),
    .loc_trig   (loc_trig),
    .glb_trig   (glb_trig),
    .loc_mark   (loc_mark),
    .glb_mark   (glb_mark),
    .tracing    (trace_on),
    .ctl_hit    (ctl_hit),
    .fwd_trig_d (fwd_trig_d),
    .fwd_mark_d (fwd_mark_d),
    .ins_d      (ins_d)
  );

  tev_stop_collect #(.N_DBG(N_DBG)) u_stop (
    .clk          (clk),
    .rst_n        (rst_n),
    .dbg_trig     (dbg_trig),
    .dbg_stop_en  (dbg_stop_en),
    .run_in       (run_in),
    .run_stop_en  (run_stop_en),
    .chkstop      (chkstop),
    .chk_stop_off (chk_stop_off),
    .stop_hit     (stop_hit)
  );

  tev_run_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_hit     (ctl_hit),
    .stop_hit    (stop_hit),
    .trace_on    (trace_on),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_trig  <= 1'b0;
      fwd_mark  <= 1'b0;
      ins_pulse <= '0;
    end else begin
      fwd_trig  <= fwd_trig_d;
      fwd_mark  <= fwd_mark_d;
      ins_pulse <= ins_d;
    end
  end

  // R4: trigger forwarding only after a local trigger in a forwarding mode
  a_r4_fwd_trig_mode: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_trig |-> $past(trig_mode[1] && loc_trig));
  // R6: marker forwarding only after a local marker in a forwarding mode
  a_r6_fwd_mark_mode: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_mark |-> $past(mark_mode[1] && loc_mark));
  // R2: nothing is inserted unless tracing was on
  a_r2_insert_needs_trace: assert property (@(posedge clk) disable iff (!rst_n)
    (|ins_pulse) |-> $past(trace_on));
  // R9: an enabled debug trigger leaves tracing off
  a_r9_dbg_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dbg_trig & dbg_stop_en)) |=> !trace_on);
  // R11: enabled checkstop leaves tracing off
  a_r11_chk_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (chkstop && !chk_stop_off) |=> !trace_on);
endmodule

// File: tb/trace_event_router_tb_top.sv
module trace_event_router_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] trig_mode = 2'b00;
  logic [1:0] mark_mode = 2'b00;
  logic       loc_trig = 1'b0, glb_trig = 1'b0, loc_mark = 1'b0, glb_mark = 1'b0;
  logic [1:0] dbg_trig = 2'b00, dbg_stop_en = 2'b00;
  logic       run_in = 1'b0, run_stop_en = 1'b0, chkstop = 1'b0, chk_stop_off = 1'b1;
  logic       fwd_trig, fwd_mark, trace_on, start_pulse, stop_pulse;
  logic [3:0] ins_pulse;

  int total = 0;
  int bad = 0;
  logic m_tr = 1'b0;
  logic m_runp = 1'b0;

  always #4 clk = ~clk;

  trace_event_router #(.N_DBG(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_mode(trig_mode), .mark_mode(mark_mode),
    .loc_trig(loc_trig), .glb_trig(glb_trig), .loc_mark(loc_mark), .glb_mark(glb_mark),
    .dbg_trig(dbg_trig), .dbg_stop_en(dbg_stop_en), .run_in(run_in),
    .run_stop_en(run_stop_en), .chkstop(chkstop), .chk_stop_off(chk_stop_off),
    .fwd_trig(fwd_trig), .fwd_mark(fwd_mark), .ins_pulse(ins_pulse),
    .trace_on(trace_on), .start_pulse(start_pulse), .stop_pulse(stop_pulse)
  );

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, predict, check at the next negedge.
  task automatic step(input logic lt, input logic gt, input logic lm, input logic gm,
                      input logic [1:0] dbg, input logic run, input logic ck, input string stag);
    logic ctl, stp, fall, nx, e_fwt, e_fwm, e_start, e_stop;
    logic [3:0] e_ins;
    string ttag, mtag;
    loc_trig = lt; glb_trig = gt; loc_mark = lm; glb_mark = gm;
    dbg_trig = dbg; run_in = run; chkstop = ck;
    ctl   = (trig_mode == 2'b00) ? (lt | gt) : (trig_mode == 2'b01) ? lt : gt;
    e_fwt = trig_mode[1] & lt;
    e_fwm = mark_mode[1] & lm;
    e_ins[0] = !trig_mode[1] & lt & m_tr;
    e_ins[1] = gt & m_tr;
    e_ins[2] = (mark_mode == 2'b00 || mark_mode == 2'b01) & lm & m_tr;
    e_ins[3] = (mark_mode == 2'b00 || mark_mode == 2'b10) & gm & m_tr;
    fall  = m_runp & ~run;
    stp   = (|(dbg & dbg_stop_en)) | (fall & run_stop_en) | (ck & ~chk_stop_off);
    nx    = stp ? 1'b0 : (ctl ? ~m_tr : m_tr);
    e_start = ~m_tr & nx;
    e_stop  = m_tr & ~nx;
    ttag = (trig_mode == 2'b00) ? "R2" : (trig_mode == 2'b01) ? "R3" : "R4";
    mtag = (mark_mode[1] == 1'b0) ? "R5" : "R6";
    @(posedge clk);
    @(negedge clk);
    check(ttag, "fwd_trig", {7'd0, fwd_trig}, {7'd0, e_fwt});
    check(ttag, "ins_trig_lanes", {6'd0, ins_pulse[1:0]}, {6'd0, e_ins[1:0]});
    check(mtag, "fwd_mark", {7'd0, fwd_mark}, {7'd0, e_fwm});
    check(mtag, "ins_mark_lanes", {6'd0, ins_pulse[3:2]}, {6'd0, e_ins[3:2]});
    check(stag, "trace_on", {7'd0, trace_on}, {7'd0, nx});
    check(stag, "start_pulse", {7'd0, start_pulse}, {7'd0, e_start});
    check(stag, "stop_pulse", {7'd0, stop_pulse}, {7'd0, e_stop});
    m_tr = nx;
    m_runp = run;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state, during and just after reset
    repeat (3) @(negedge clk);
    check("R1", "outputs_in_reset", {2'd0, fwd_trig, fwd_mark, trace_on, start_pulse, stop_pulse, |ins_pulse}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "outputs_after_reset", {2'd0, fwd_trig, fwd_mark, trace_on, start_pulse, stop_pulse, |ins_pulse}, 8'd0);

    // R12: one-cycle latency on forwarding and on the start
    trig_mode = 2'b10; loc_trig = 1'b1; glb_trig = 1'b1;
    #1;
    check("R12", "fwd_same_cycle", {7'd0, fwd_trig}, 8'd0);
    check("R12", "start_same_cycle", {7'd0, trace_on}, 8'd0);
    @(posedge clk); @(negedge clk);
    check("R12", "fwd_next_cycle", {7'd0, fwd_trig}, 8'd1);
    check("R12", "start_next_cycle", {7'd0, start_pulse}, 8'd1);
    m_tr = 1'b1;
    step(0, 1, 0, 0, 2'b00, 0, 0, "R7");

    // Sweep of every mode pair and event combination (R2-R7)
    for (int t = 0; t < 4; t++) begin
      for (int m = 0; m < 4; m++) begin
        trig_mode = t[1:0]; mark_mode = m[1:0];
        for (int ev = 0; ev < 16; ev++) begin
          step(ev[0], ev[1], ev[2], ev[3], 2'b00, 0, 0, "R7");
          step(0, 0, ev[2], ev[3], 2'b00, 0, 0, "R7");
        end
      end
    end

    // Stop source sweep: all enable settings against all source patterns (R9)
    trig_mode = 2'b01; mark_mode = 2'b11;
    for (int cfg = 0; cfg < 16; cfg++) begin
      dbg_stop_en = cfg[1:0]; run_stop_en = cfg[2]; chk_stop_off = cfg[3];
      for (int p = 0; p < 32; p++) begin
        step(p[4], 0, 0, 0, p[1:0], p[2], p[3], "R9");
        step(1, 0, 0, 0, 2'b00, p[2], 0, "R9");
      end
    end

    // R8: stop and start in the same cycle while off
    dbg_stop_en = 2'b01; run_stop_en = 1'b0; chk_stop_off = 1'b1;
    if (m_tr) step(1, 0, 0, 0, 2'b00, 0, 0, "R8");
    step(1, 0, 0, 0, 2'b01, 0, 0, "R8");
    check("R8", "no_start_under_stop", {7'd0, start_pulse}, 8'd0);

    // R10: run falling edge stop, enabled then disabled
    dbg_stop_en = 2'b00; run_stop_en = 1'b1;
    step(0, 0, 0, 0, 2'b00, 1, 0, "R10");
    step(1, 0, 0, 0, 2'b00, 1, 0, "R10");
    step(0, 0, 0, 0, 2'b00, 0, 0, "R10");
    check("R10", "fall_stops", {7'd0, trace_on}, 8'd0);
    run_stop_en = 1'b0;
    step(0, 0, 0, 0, 2'b00, 1, 0, "R10");
    step(1, 0, 0, 0, 2'b00, 1, 0, "R10");
    step(0, 0, 0, 0, 2'b00, 0, 0, "R10");
    check("R10", "fall_ignored", {7'd0, trace_on}, 8'd1);

    // R11: checkstop with active-low enable
    chk_stop_off = 1'b1;
    step(0, 0, 0, 0, 2'b00, 0, 1, "R11");
    check("R11", "chk_ignored", {7'd0, trace_on}, 8'd1);
    chk_stop_off = 1'b0;
    step(0, 0, 0, 0, 2'b00, 0, 1, "R11");
    check("R11", "chk_stops", {7'd0, trace_on}, 8'd0);
    step(0, 0, 0, 0, 2'b00, 0, 0, "R11");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule